// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract Unit

This block adds or subtracts two 8-bit operands with a carry input and produces an 8-bit result with carry, zero, negative and overflow flags. A mode input picks plain two's-complement arithmetic or packed decimal arithmetic, where each 4-bit digit holds a value from 0 to 9 and a decimal correction is applied digit by digit, with the carry (add) or borrow (subtract) passed from the low digit to the high digit.

The arithmetic is purely combinational. A one-cycle start strobe captures its output into a result register, which plays the role of the accumulator, and into the four flag registers. Outputs then stay unchanged until the next strobe, whatever the operand and control inputs do in between. Digit values of 10 to 15 on the operands in decimal mode are outside the defined range.

Top module: `dec_addsub_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state is result 0x00, flag_z 1, and flag_c, flag_n, flag_v 0.
- R2: The outputs change only on a clock edge where start is 1; with start 0 they keep their values regardless of the other inputs.
- R3: Binary add (sub_sel 0, dec_mode 0): result is (A + M + carry_in) mod 256 and flag_c is 1 exactly when that sum exceeds 255.
- R4: Binary subtract (sub_sel 1, dec_mode 0): result is (A − M − 1 + carry_in) mod 256 and flag_c is 1 exactly when no borrow occurs, that is when A ≥ M + 1 − carry_in.
- R5: In every mode flag_v is 1 exactly when bit 7 of A equals bit 7 of M and bit 7 of the result differs from bit 7 of A.
- R6: flag_z is 1 exactly when the 8-bit result is zero; flag_n equals bit 7 of the result.
- R7: Decimal add (sub_sel 1'b0, dec_mode 1): the low digit (bits 3:0) is A_lo + M_lo + carry_in, reduced by 10 with a carry into the high digit when it reaches 10 or more.
- R8: Decimal add: the high digit (bits 7:4) is A_hi + M_hi + low carry; when it reaches 10 or more it is reduced by 10 and flag_c is 1, otherwise flag_c is 0.
- R9: Decimal subtract (sub_sel 1, dec_mode 1): the low digit is A_lo − M_lo − 1 + carry_in; when negative, 10 is added and one is borrowed from the high digit.
- R10: Decimal subtract: the high digit is A_hi − M_hi − low borrow; when negative, 10 is added and flag_c is 0, otherwise flag_c is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that captures a new result |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| dec_mode | input | 1 | 0 = binary, 1 = packed decimal |
| carry_in | input | 1 | Carry in (add) or not-borrow in (subtract) |
| opnd_a | input | 8 | Operand A |
| opnd_m | input | 8 | Operand M |
| result | output | 8 | Registered result (accumulator) |
| flag_c | output | 1 | Carry / not-borrow out |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Bit 7 of result |
| flag_v | output | 1 | Signed overflow as defined in R5 |

## Verification
Every fault in the data paths reaches the ports one cycle after the strobe, since the result and flags are a single register stage away from the arithmetic. A wrong digit carry shows as a high digit off by one or a low digit left at 10 to 15, and a wrong borrow polarity shows as flag_c inverted on subtraction; the vectors therefore sit on the 9/10 and 0/−1 digit boundaries in both directions. A capture register that loads without the strobe shows as the outputs following the operands during idle cycles, checked over several cycles of changing inputs.

// File: rtl/addsub_pkg.sv
// Package: shared constants and the flag bundle for the add/subtract unit.
// Assumes decimal digits are 4 bits wide and use base ten.
package addsub_pkg;
    localparam int DIGIT_W  = 4;
    localparam int DEC_BASE = 10;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } addsub_flags_t;
endpackage

// File: rtl/addsub_bin_path.sv
// Binary adder/subtractor. Subtraction adds the inverted M, so the carry
// out is the not-borrow. Assumes nothing about operand encoding.
module addsub_bin_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         ci,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W-1:0] m_eff;

    // Choose M or its complement for the operation.
    always_comb m_eff = sub ? ~m : m;

    // One W+1 bit addition gives both the sum and the carry out.
    always_comb {co, sum} = {1'b0, a} + {1'b0, m_eff} + {{W{1'b0}}, ci};
endmodule

// File: rtl/addsub_bcd_cell.sv
// One decimal digit of the adder/subtractor. ci/co are carry for add and
// not-borrow for subtract. Assumes digit inputs in 0..9.
module addsub_bcd_cell
    import addsub_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] m,
    input  logic               ci,
    input  logic               sub,
    output logic [DIGIT_W-1:0] d,
    output logic               co
);
    localparam logic [DIGIT_W:0]   BASE_S = DIGIT_W'(DEC_BASE);
    localparam logic [DIGIT_W-1:0] BASE_D = DIGIT_W'(DEC_BASE);

    logic [DIGIT_W:0]   add_raw;
    logic [DIGIT_W+1:0] sub_raw;

    // Raw digit sum and difference before decimal correction.
    always_comb begin
        add_raw = {1'b0, a} + {1'b0, m} + {{DIGIT_W{1'b0}}, ci};
        sub_raw = {2'b00, a} - {2'b00, m} - {{(DIGIT_W+1){1'b0}}, ~ci};
    end

    // Decimal correction and carry/borrow out.
    always_comb begin
        if (sub) begin
            if (sub_raw[DIGIT_W+1]) begin
                d  = sub_raw[DIGIT_W-1:0] + BASE_D;
                co = 1'b0;
            end else begin
                d  = sub_raw[DIGIT_W-1:0];
                co = 1'b1;
            end
        end else begin
            if (add_raw >= BASE_S) begin
                d  = DIGIT_W'(add_raw - BASE_S);
                co = 1'b1;
            end else begin
                d  = add_raw[DIGIT_W-1:0];
                co = 1'b0;
            end
        end
    end
endmodule

// File: rtl/addsub_bcd_path.sv
// Packed-decimal adder/subtractor: a ripple chain of digit cells, digit 0
// in the least significant bits. Assumes every operand digit is 0..9.
module addsub_bcd_path
    import addsub_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W     = DIGITS * DIGIT_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         ci,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [DIGITS:0] chain;

    // Carry/borrow enters at the low digit.
    always_comb chain[0] = ci;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        addsub_bcd_cell u_cell (
            .a   (a[g*DIGIT_W +: DIGIT_W]),
            .m   (m[g*DIGIT_W +: DIGIT_W]),
            .ci  (chain[g]),
            .sub (sub),
            .d   (sum[g*DIGIT_W +: DIGIT_W]),
            .co  (chain[g+1])
        );
    end

    // Carry/borrow out of the top digit.
    always_comb co = chain[DIGITS];
endmodule

// File: rtl/dec_addsub_unit.sv
// Top: binary or packed-decimal add/subtract with a registered result and
// flags, loaded on a one-cycle start strobe and held otherwise.
// Assumes synchronous active-low reset and decimal digits in 0..9.
module dec_addsub_unit
    import addsub_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W     = DIGITS * DIGIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sub_sel,
    input  logic         dec_mode,
    input  logic         carry_in,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_m,
    output logic [W-1:0] result,
    output logic         flag_c,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_v
);
    logic [W-1:0]  bin_sum;
    logic          bin_co;
    logic [W-1:0]  dec_sum;
    logic          dec_co;
    logic [W-1:0]  nxt_res;
    addsub_flags_t nxt_flg;
    addsub_flags_t flg_q;
    logic [W-1:0]  res_q;

    addsub_bin_path #(.W(W)) u_bin (
        .a   (opnd_a),
        .m   (opnd_m),
        .ci  (carry_in),
        .sub (sub_sel),
        .sum (bin_sum),
        .co  (bin_co)
    );

    addsub_bcd_path #(.DIGITS(DIGITS)) u_bcd (
        .a   (opnd_a),
        .m   (opnd_m),
        .ci  (carry_in),
        .sub (sub_sel),
        .sum (dec_sum),
        .co  (dec_co)
    );

    // Select the mode's result and derive the next flags from it.
    always_comb begin
        nxt_res   = dec_mode ? dec_sum : bin_sum;
        nxt_flg.c = dec_mode ? dec_co : bin_co;
        nxt_flg.z = (nxt_res == '0);
        nxt_flg.n = nxt_res[W-1];
        nxt_flg.v = (opnd_a[W-1] == opnd_m[W-1]) && (nxt_res[W-1] != opnd_a[W-1]);
    end

    // Accumulator and flag register: reset, load on strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '{c: 1'b0, z: 1'b1, n: 1'b0, v: 1'b0};
        end else if (start) begin
            res_q <= nxt_res;
            flg_q <= nxt_flg;
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        result = res_q;
        flag_c = flg_q.c;
        flag_z = flg_q.z;
        flag_n = flg_q.n;
        flag_v = flg_q.v;
    end
endmodule

// File: rtl/dec_addsub_unit_chk.sv
// Checker for dec_addsub_unit: relates captured outputs to the inputs seen
// at the strobe. Observes ports only.
module dec_addsub_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         sub_sel,
    input logic         dec_mode,
    input logic         carry_in,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_m,
    input logic [W-1:0] result,
    input logic         flag_c,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_v
);
    logic [W:0] ref_add;
    logic [W:0] ref_sub;
    logic       ops_bcd_ok;

    // Independent binary references and a decimal-operand validity test.
    always_comb begin
        ref_add = {1'b0, opnd_a} + {1'b0, opnd_m} + {{W{1'b0}}, carry_in};
        ref_sub = {1'b0, opnd_a} - {1'b0, opnd_m} - {{W{1'b0}}, ~carry_in};
        ops_bcd_ok = 1'b1;
        for (int i = 0; i < W / 4; i++) begin
            if (opnd_a[i*4 +: 4] > 4'd9 || opnd_m[i*4 +: 4] > 4'd9) ops_bcd_ok = 1'b0;
        end
    end

    function automatic logic digits_ok(input logic [W-1:0] x);
        logic ok = 1'b1;
        for (int i = 0; i < W / 4; i++) if (x[i*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && flag_z && !flag_c && !flag_n && !flag_v);

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result) && $stable({flag_c, flag_z, flag_n, flag_v}));

    a_r3_bin_add: assert property (@(posedge clk) disable iff (!rst_n)
        start && !dec_mode && !sub_sel |=> {flag_c, result} == $past(ref_add));

    // R4: carry out equals not-borrow
    a_r4_bin_sub: assert property (@(posedge clk) disable iff (!rst_n)
        start && !dec_mode && sub_sel |=> {!flag_c, result} == $past(ref_sub));

    a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> flag_v == ($past(opnd_a[W-1] == opnd_m[W-1])
                             && (result[W-1] != $past(opnd_a[W-1]))));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z == (result == '0));

    a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_n == result[W-1]);

    // R7 / R9: decimal results stay decimal for decimal operands
    a_r7_dec_digits: assert property (@(posedge clk) disable iff (!rst_n)
        start && dec_mode && ops_bcd_ok |=> digits_ok(result));
endmodule

bind dec_addsub_unit dec_addsub_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sub_sel  (sub_sel),
    .dec_mode (dec_mode),
    .carry_in (carry_in),
    .opnd_a   (opnd_a),
    .opnd_m   (opnd_m),
    .result   (result),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_v   (flag_v)
);

// File: tb/test_dec_addsub_unit.sv
module test_dec_addsub_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       sub_sel = 1'b0;
    logic       dec_mode = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_m = 8'h00;
    logic [7:0] result;
    logic       flag_c, flag_z, flag_n, flag_v;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    dec_addsub_unit i_dec_addsub_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sub_sel  (sub_sel),
        .dec_mode (dec_mode),
        .carry_in (carry_in),
        .opnd_a   (opnd_a),
        .opnd_m   (opnd_m),
        .result   (result),
        .flag_c   (flag_c),
        .flag_z   (flag_z),
        .flag_n   (flag_n),
        .flag_v   (flag_v)
    );

    always #10 clk = ~clk;

    // {sub, dec, cin, A, M, expected result, expected C, expected V}
    localparam int NV = 17;
    localparam logic [28:0] VECS [NV] = '{
        // R3 binary add
        {1'b0, 1'b0, 1'b0, 8'h10, 8'h20, 8'h30, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
        {1'b0, 1'b0, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b1, 8'h80, 8'h80, 8'h01, 1'b1, 1'b1},
        // R4 binary subtract
        {1'b1, 1'b0, 1'b1, 8'h50, 8'h20, 8'h30, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b1, 8'h20, 8'h50, 8'hD0, 1'b0, 1'b1},
        {1'b1, 1'b0, 1'b0, 8'h05, 8'h05, 8'hFF, 1'b0, 1'b1},
        {1'b1, 1'b0, 1'b0, 8'h05, 8'h04, 8'h00, 1'b1, 1'b0},
        // R7 R8 decimal add
        {1'b0, 1'b1, 1'b0, 8'h25, 8'h48, 8'h73, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 8'h99, 8'h01, 8'h00, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 8'h58, 8'h46, 8'h05, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 8'h45, 8'h44, 8'h90, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b0, 8'h09, 8'h01, 8'h10, 1'b0, 1'b0},
        // R9 R10 decimal subtract
        {1'b1, 1'b1, 1'b1, 8'h42, 8'h17, 8'h25, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'h10, 8'h20, 8'h90, 1'b0, 1'b1},
        {1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h99, 1'b0, 1'b1},
        {1'b1, 1'b1, 1'b1, 8'h50, 8'h50, 8'h00, 1'b1, 1'b0}
    };

    // Compare all outputs; Z and N follow the expected result (R6).
    task automatic check_out(input string tag, input logic [7:0] er,
                             input logic ec, input logic ev);
        logic ez = (er == 8'h00);
        logic en = er[7];
        n_chk++;
        if (result !== er || flag_c !== ec || flag_z !== ez ||
            flag_n !== en || flag_v !== ev) begin
            n_fail++;
            $display("FAIL %s: actual res=%h c=%b z=%b n=%b v=%b expected res=%h c=%b z=%b n=%b v=%b",
                     tag, result, flag_c, flag_z, flag_n, flag_v, er, ec, ez, en, ev);
        end
    endtask

    // Drive one operation with a single-cycle strobe; outputs valid at next negedge.
    task automatic apply(input logic s, input logic d, input logic c,
                         input logic [7:0] a, input logic [7:0] m);
        @(negedge clk);
        sub_sel = s; dec_mode = d; carry_in = c; opnd_a = a; opnd_m = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 reset state", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v = VECS[i];
            string tag;
            case (v[28:27])
                2'b00:   tag = "R3 R5 R6 bin add";
                2'b10:   tag = "R4 R5 R6 bin sub";
                2'b01:   tag = "R7 R8 R5 R6 dec add";
                default: tag = "R9 R10 R5 R6 dec sub";
            endcase
            apply(v[28], v[27], v[26], v[25:18], v[17:10]);
            check_out(tag, v[9:2], v[1], v[0]);
        end

        // R3 versus R7: same operands in binary mode give the uncorrected sum
        apply(1'b0, 1'b0, 1'b0, 8'h09, 8'h01);
        check_out("R3 mode select", 8'h0A, 1'b0, 1'b0);

        // R2: inputs move without a strobe, outputs must hold
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            sub_sel = k[0]; dec_mode = k[1]; carry_in = ~k[0];
            opnd_a = 8'hF0 ^ 8'(k * 37); opnd_m = 8'h3C + 8'(k);
            @(negedge clk);
            check_out("R2 hold without strobe", 8'h0A, 1'b0, 1'b0);
        end

        // R1: reset after a result with C and V set
        apply(1'b0, 1'b0, 1'b1, 8'h80, 8'h80);
        check_out("R3 R5 before reset", 8'h01, 1'b1, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check_out("R1 reset clears", 8'h00, 1'b0, 1'b0);

        // R1: a strobe during reset is ignored
        @(negedge clk);
        rst_n = 1'b0; start = 1'b1; sub_sel = 1'b0; dec_mode = 1'b0;
        carry_in = 1'b0; opnd_a = 8'h44; opnd_m = 8'h11;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b1;
        check_out("R1 strobe under reset", 8'h00, 1'b0, 1'b0);

        // R9 R10 after reset: borrow through both digits with carry_in 0
        apply(1'b1, 1'b1, 1'b0, 8'h10, 8'h00);
        check_out("R9 R10 chained borrow", 8'h09, 1'b1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule